// File: doc/BRIEF.md
# Transfer Count and DMA Length Unit

This unit decides how many bytes a single transfer-information command moves and follows that amount down to zero as the data side moves it. When a start pulse arrives it takes a 16-bit byte count from two 8-bit halves, where a count of zero stands for 65536. It compares that count with a limit. In command phase the limit is a fixed 32 bytes. Otherwise the limit is the magnitude of a signed pending-size register. The smaller value is loaded as the remaining length. The sign of the pending size sets the direction: negative means toward the target and zero or positive means toward the host. Command phase always counts as toward the target.

Each cycle the unit moves one piece. The piece is the smaller of the remaining length and a per-cycle availability input, and the unit waits while availability is zero. Each piece is reported on the outputs and changes the pending size. When the remaining length reaches zero, the unit signals completion in one of two ways:
- at once, or
- for a toward-host transfer that still expects data, later, when a data-chunk arrival finds the pending size at or below zero.

Completion raises a one-cycle done/interrupt event. It also sets the terminal-count flag, puts the done code 0x10 in the interrupt-code register and clears the visible count.

Top module: `tcl_xfer_unit`

## Requirements
- R1: The transfer length is `{cnt_mid_i, cnt_lo_i}`, and a value of 0 means 65536. The chunk length never exceeds this length.
- R2: With `cmd_phase_i` high at start, the chunk length is min(length, 32) and `to_target_o` is 1. The pieces of such a transfer leave `pending_o` unchanged.
- R3: Outside command phase, a negative pending size gives `to_target_o`=1 and chunk = min(length, -pending). A pending size of zero or more gives `to_target_o`=0 and chunk = min(length, pending).
- R4: One cycle after `start_i` the following hold: `chunk_len_o` and `remain_o` equal the chunk, `tc_o` is 0, and `cnt_view_o` equals `{cnt_mid_i, cnt_lo_i}`.
- R5: While a transfer runs, each cycle moves piece = min(remaining, `avail_i`). The piece is shown one cycle later on `piece_valid_o`/`piece_len_o`, and `remain_o` drops by the piece. When `avail_i` is 0 nothing moves and `remain_o` holds.
- R6: Each piece adds its length to `pending_o` toward the target and subtracts it toward the host. A `pend_ld_i` pulse loads `pend_val_i` into the pending register, and the load takes priority over a piece adjustment in the same cycle.
- R7: When the remaining length reaches zero in a transfer toward the target, or toward the host with the updated pending size equal to 0, completion happens. `done_o` pulses in the same cycle as the last piece (or one cycle after start for a zero chunk). From then on `tc_o`=1, `intr_code_o`=0x10 and `cnt_view_o`=0.
- R8: A toward-host transfer that ends with a non-zero pending size does not complete. Later, a `chunk_arrive_i` pulse completes it one cycle later if the pending size is ≤ 0 at that moment. A pulse with a positive pending size does nothing.
- R9: A `start_i` pulse during a running transfer restarts the unit. In that cycle no piece moves, and the old remaining length is discarded.
- R10: After reset the following are all 0: `chunk_len_o`, `remain_o`, `pending_o`, `tc_o`, `intr_code_o`, `done_o` and `piece_valid_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_lo_i | input | CNT_W | Low byte of programmed count |
| cnt_mid_i | input | CNT_W | Mid byte of programmed count |
| cmd_phase_i | input | 1 | Command phase flag, sampled at start |
| pend_ld_i | input | 1 | Load pending size |
| pend_val_i | input | PEND_W | Signed pending size to load |
| start_i | input | 1 | Transfer-information command (DMA start) |
| avail_i | input | 2*CNT_W+1 | Bytes the data side can accept this cycle |
| chunk_arrive_i | input | 1 | Next data chunk arrived (releases a deferred completion) |
| chunk_len_o | output | 2*CNT_W+1 | Chunk length of current transfer |
| to_target_o | output | 1 | Direction: 1 toward target, 0 toward host |
| remain_o | output | 2*CNT_W+1 | Remaining DMA length |
| pending_o | output | PEND_W | Signed pending size |
| piece_valid_o | output | 1 | A piece moved in the last cycle |
| piece_len_o | output | 2*CNT_W+1 | Length of that piece |
| done_o | output | 1 | Completion/interrupt event pulse |
| tc_o | output | 1 | Terminal-count status flag |
| intr_code_o | output | 8 | Interrupt code, 0x10 after completion |
| cnt_view_o | output | 2*CNT_W | Visible transfer count, cleared on completion |

## Verification
A restart can fall in the same cycle as a piece advance. The bench provokes this by raising `start_i` while `avail_i` is non-zero partway through a running transfer. It then judges three things:
- no piece is reported for that edge;
- the new chunk is computed from the pending size the earlier pieces left behind;
- the scoreboard sees only the pieces and completion of the new transfer.

The bench also lines up the last piece with completion and checks that both events appear in the same cycle, in order.

// File: rtl/tcl_pkg.sv
package tcl_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_WAIT = 2'd2
  } xfer_st_t;

  localparam logic [7:0] INTR_DONE_CODE = 8'h10;
  localparam int unsigned CMD_CAP_BYTES = 32;
endpackage

// File: rtl/tcl_len_calc.sv
module tcl_len_calc #(
  parameter int CNT_W  = 8,
  parameter int PEND_W = 20,
  parameter int CAP    = 32
) (
  input  logic [CNT_W-1:0]         lo_i,
  input  logic [CNT_W-1:0]         mid_i,
  input  logic signed [PEND_W-1:0] pend_i,
  input  logic                     cmd_i,
  output logic [2*CNT_W:0]         chunk_o,
  output logic                     to_target_o
);
  localparam int LEN_W = 2*CNT_W + 1;
  localparam int CW    = (PEND_W + 1 > LEN_W) ? PEND_W + 1 : LEN_W + 1;

  logic [2*CNT_W-1:0] raw;
  logic [LEN_W-1:0]   len_full;
  logic [CW-1:0]      pe, mag, lim, len_x, pick;

  always_comb begin
    raw = {mid_i, lo_i};
    len_full = (raw == '0) ? {1'b1, {(2*CNT_W){1'b0}}} : {1'b0, raw};
    len_x = CW'(len_full);
    pe = CW'(pend_i);
    mag = pe[CW-1] ? (~pe + CW'(1)) : pe;
    lim = cmd_i ? CW'(CAP) : mag;
    pick = (len_x < lim) ? len_x : lim;
    chunk_o = pick[LEN_W-1:0];
    to_target_o = cmd_i | pend_i[PEND_W-1];
    p_chunk_le_len_r1: assert (pick <= len_x);
  end
endmodule

// File: rtl/tcl_piece_gen.sv
module tcl_piece_gen #(
  parameter int LEN_W = 17
) (
  input  logic [LEN_W-1:0] remain_i,
  input  logic [LEN_W-1:0] avail_i,
  output logic [LEN_W-1:0] piece_o,
  output logic [LEN_W-1:0] rem_next_o
);
  always_comb begin
    piece_o = (avail_i < remain_i) ? avail_i : remain_i;
    rem_next_o = remain_i - piece_o;
  end
endmodule

// File: rtl/tcl_pend_track.sv
module tcl_pend_track #(
  parameter int PEND_W = 20,
  parameter int LEN_W  = 17
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ld_i,
  input  logic signed [PEND_W-1:0] ld_val_i,
  input  logic                     adj_i,
  input  logic                     to_target_i,
  input  logic [LEN_W-1:0]         piece_i,
  output logic signed [PEND_W-1:0] pend_o,
  output logic signed [PEND_W-1:0] pend_next_o
);
  logic signed [PEND_W-1:0] pend_q, pc;

  always_comb begin
    pc = $signed(PEND_W'(piece_i));
    if (ld_i)
      pend_next_o = ld_val_i;
    else if (adj_i)
      pend_next_o = to_target_i ? (pend_q + pc) : (pend_q - pc);
    else
      pend_next_o = pend_q;
  end

  always_ff @(posedge clk) begin
    if (rst) pend_q <= '0;
    else     pend_q <= pend_next_o;
  end

  assign pend_o = pend_q;

  // R6: without load or adjustment the pending size holds
  p_pend_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (!ld_i && (!adj_i || piece_i == '0)) |=> pend_q == $past(pend_q));
endmodule

// File: rtl/tcl_xfer_unit.sv
module tcl_xfer_unit
  import tcl_pkg::*;
#(
  parameter int CNT_W  = 8,
  parameter int PEND_W = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [CNT_W-1:0]         cnt_lo_i,
  input  logic [CNT_W-1:0]         cnt_mid_i,
  input  logic                     cmd_phase_i,
  input  logic                     pend_ld_i,
  input  logic signed [PEND_W-1:0] pend_val_i,
  input  logic                     start_i,
  input  logic [2*CNT_W:0]         avail_i,
  input  logic                     chunk_arrive_i,
  output logic [2*CNT_W:0]         chunk_len_o,
  output logic                     to_target_o,
  output logic [2*CNT_W:0]         remain_o,
  output logic signed [PEND_W-1:0] pending_o,
  output logic                     piece_valid_o,
  output logic [2*CNT_W:0]         piece_len_o,
  output logic                     done_o,
  output logic                     tc_o,
  output logic [7:0]               intr_code_o,
  output logic [2*CNT_W-1:0]       cnt_view_o
);
  localparam int LEN_W = 2*CNT_W + 1;

  xfer_st_t                 state_q;
  logic [LEN_W-1:0]         chunk_q, remain_q, piece_len_q;
  logic                     dir_q, piece_v_q, done_q, tc_q;
  logic [7:0]               intr_q;
  logic [2*CNT_W-1:0]       view_q;

  logic [LEN_W-1:0]         calc_chunk, piece, rem_next;
  logic                     calc_dir, running, adj, fire, last;
  logic signed [PEND_W-1:0] pend_q, pend_nxt;

  tcl_len_calc #(.CNT_W(CNT_W), .PEND_W(PEND_W), .CAP(CMD_CAP_BYTES)) u_len (
    .lo_i(cnt_lo_i), .mid_i(cnt_mid_i), .pend_i(pend_q), .cmd_i(cmd_phase_i),
    .chunk_o(calc_chunk), .to_target_o(calc_dir));

  tcl_piece_gen #(.LEN_W(LEN_W)) u_piece (
    .remain_i(remain_q), .avail_i(avail_i), .piece_o(piece), .rem_next_o(rem_next));

  logic cmd_q;
  assign running = (state_q == ST_RUN) && !start_i;
  assign adj     = running && !cmd_q;

  tcl_pend_track #(.PEND_W(PEND_W), .LEN_W(LEN_W)) u_pend (
    .clk(clk), .rst(rst), .ld_i(pend_ld_i), .ld_val_i(pend_val_i), .adj_i(adj),
    .to_target_i(dir_q), .piece_i(piece), .pend_o(pend_q), .pend_next_o(pend_nxt));

  always_comb begin
    last = running && (rem_next == '0);
    fire = (last && (dir_q || pend_nxt == '0)) ||
           (!start_i && state_q == ST_WAIT && chunk_arrive_i && pend_q <= 0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_IDLE;
      chunk_q <= '0;
      remain_q <= '0;
      piece_len_q <= '0;
      dir_q <= 1'b0;
      cmd_q <= 1'b0;
      piece_v_q <= 1'b0;
      done_q <= 1'b0;
      tc_q <= 1'b0;
      intr_q <= '0;
      view_q <= '0;
    end else begin
      piece_v_q <= 1'b0;
      done_q <= 1'b0;
      if (start_i) begin
        state_q <= ST_RUN;
        chunk_q <= calc_chunk;
        remain_q <= calc_chunk;
        dir_q <= calc_dir;
        cmd_q <= cmd_phase_i;
        tc_q <= 1'b0;
        view_q <= {cnt_mid_i, cnt_lo_i};
      end else begin
        if (running) begin
          if (piece != '0) begin
            piece_v_q <= 1'b1;
            piece_len_q <= piece;
            remain_q <= rem_next;
          end
          if (last) state_q <= fire ? ST_IDLE : ST_WAIT;
        end else if (fire) begin
          state_q <= ST_IDLE;
        end
        if (fire) begin
          done_q <= 1'b1;
          tc_q <= 1'b1;
          intr_q <= INTR_DONE_CODE;
          view_q <= '0;
        end
      end
    end
  end

  assign chunk_len_o   = chunk_q;
  assign to_target_o   = dir_q;
  assign remain_o      = remain_q;
  assign pending_o     = pend_q;
  assign piece_valid_o = piece_v_q;
  assign piece_len_o   = piece_len_q;
  assign done_o        = done_q;
  assign tc_o          = tc_q;
  assign intr_code_o   = intr_q;
  assign cnt_view_o    = view_q;

  // R4: start loads remaining length and clears terminal count
  p_start_load_r4: assert property (@(posedge clk) disable iff (rst)
    start_i |=> (!tc_o && remain_o == chunk_len_o && !done_o));

  // R5: zero availability stalls a running transfer
  p_stall_r5: assert property (@(posedge clk) disable iff (rst)
    (running && avail_i == '0 && remain_q != '0) |=> (!piece_valid_o && $stable(remain_q)));

  // R7: completion leaves terminal count, done code and cleared count
  p_done_codes_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (tc_o && intr_code_o == INTR_DONE_CODE && cnt_view_o == '0 && remain_o == '0));

  // R8: a deferred transfer does not complete without a chunk arrival
  p_defer_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT && !chunk_arrive_i && !start_i) |=> !done_o);

  // R9: a restart cycle reports no piece
  p_restart_r9: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !piece_valid_o);
endmodule

// File: tb/tcl_xfer_unit_tb.sv
module tcl_xfer_unit_tb_top;
  localparam int CNT_W = 8;
  localparam int PEND_W = 20;
  localparam int LEN_W = 2*CNT_W + 1;

  logic clk = 0, rst = 1;
  logic [CNT_W-1:0] cnt_lo_i = 0, cnt_mid_i = 0;
  logic cmd_phase_i = 0, pend_ld_i = 0, start_i = 0, chunk_arrive_i = 0;
  logic signed [PEND_W-1:0] pend_val_i = 0;
  logic [LEN_W-1:0] avail_i = 0;
  logic [LEN_W-1:0] chunk_len_o, remain_o, piece_len_o;
  logic to_target_o, piece_valid_o, done_o, tc_o;
  logic signed [PEND_W-1:0] pending_o;
  logic [7:0] intr_code_o;
  logic [2*CNT_W-1:0] cnt_view_o;

  int checks = 0, errors = 0;
  int exp_q[$];

  always #5 clk = ~clk;

  tcl_xfer_unit #(.CNT_W(CNT_W), .PEND_W(PEND_W)) dut_i (
    .clk(clk), .rst(rst), .cnt_lo_i(cnt_lo_i), .cnt_mid_i(cnt_mid_i),
    .cmd_phase_i(cmd_phase_i), .pend_ld_i(pend_ld_i), .pend_val_i(pend_val_i),
    .start_i(start_i), .avail_i(avail_i), .chunk_arrive_i(chunk_arrive_i),
    .chunk_len_o(chunk_len_o), .to_target_o(to_target_o), .remain_o(remain_o),
    .pending_o(pending_o), .piece_valid_o(piece_valid_o), .piece_len_o(piece_len_o),
    .done_o(done_o), .tc_o(tc_o), .intr_code_o(intr_code_o), .cnt_view_o(cnt_view_o));

  task automatic chk(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // monitor: pops expected pieces (>0) and completions (-1)
  always @(negedge clk) begin
    if (!rst) begin
      if (piece_valid_o) begin
        if (exp_q.size() == 0) chk("R5 unexpected piece", int'(piece_len_o), 0);
        else chk("R5 piece", int'(piece_len_o), exp_q.pop_front());
      end
      if (done_o) begin
        if (exp_q.size() == 0) chk("R7 unexpected done", 1, 0);
        else chk("R7 done", -1, exp_q.pop_front());
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic load_pend(int p);
    pend_ld_i = 1; pend_val_i = PEND_W'(p); tick(); pend_ld_i = 0;
  endtask

  task automatic xfer(string tag, int lo, int mid, int pend, bit cmd, int av, int stall);
    int len, chunk, r, n, pf;
    bit dir, defer;
    len = (mid * 256 + lo == 0) ? 65536 : mid * 256 + lo;
    if (cmd) chunk = (len < 32) ? len : 32;
    else if (pend < 0) chunk = (len < -pend) ? len : -pend;
    else chunk = (len < pend) ? len : pend;
    dir = cmd || pend < 0;
    pf = cmd ? pend : (dir ? pend + chunk : pend - chunk);
    defer = !dir && pf != 0;
    load_pend(pend);
    cnt_lo_i = CNT_W'(lo); cnt_mid_i = CNT_W'(mid); cmd_phase_i = cmd;
    start_i = 1; tick(); start_i = 0;
    @(negedge clk);
    chk({tag, " R1/R3 chunk"}, int'(chunk_len_o), chunk);
    chk({tag, " R3 dir"}, int'(to_target_o), int'(dir));
    chk({tag, " R4 remain"}, int'(remain_o), chunk);
    chk({tag, " R4 tc clear"}, int'(tc_o), 0);
    chk({tag, " R4 count view"}, int'(cnt_view_o), mid * 256 + lo);
    repeat (stall) begin
      @(negedge clk);
      chk({tag, " R5 stall hold"}, int'(remain_o), chunk);
    end
    r = chunk; n = 0;
    while (r > 0) begin
      int p = (r < av) ? r : av;
      exp_q.push_back(p); r -= p; n++;
    end
    if (!defer) exp_q.push_back(-1);
    avail_i = LEN_W'(av);
    repeat (n + 2) @(posedge clk);
    #1 avail_i = 0;
    @(negedge clk);
    chk({tag, " R6 pending"}, int'(pending_o), pf);
    chk({tag, " R7/R8 tc"}, int'(tc_o), int'(!defer));
    chk({tag, " R5 remain zero"}, int'(remain_o), 0);
    chk({tag, " scoreboard drained"}, exp_q.size(), 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) tick();
    rst = 0;
    @(negedge clk);
    // R10 reset state
    chk("R10 chunk", int'(chunk_len_o), 0);
    chk("R10 remain", int'(remain_o), 0);
    chk("R10 pending", int'(pending_o), 0);
    chk("R10 tc", int'(tc_o), 0);
    chk("R10 intr", int'(intr_code_o), 0);
    chk("R10 done/piece", int'(done_o) + int'(piece_valid_o), 0);

    xfer("T1", 8'h40, 0, 30, 0, 8, 0);          // R3 positive limit
    chk("R7 intr code", int'(intr_code_o), 16);
    chk("R7 view clear", int'(cnt_view_o), 0);
    xfer("T2", 0, 0, -100000, 0, 40000, 0);     // R1 zero means 65536
    xfer("T3", 5, 1, -1000, 0, 100, 0);         // R1 mid byte
    xfer("T4", 50, 0, 5, 1, 20, 0);             // R2 command cap
    xfer("T5", 20, 0, -50, 0, 3, 4);            // R5 stall
    xfer("T6", 10, 0, -3, 0, 2, 0);             // R3 magnitude limit
    xfer("T7", 9, 0, 0, 0, 4, 0);               // R7 zero chunk

    // R8 deferred completion
    xfer("T8", 4, 0, 10, 0, 4, 0);
    chunk_arrive_i = 1; tick(); chunk_arrive_i = 0;
    repeat (2) tick();
    chk("R8 positive pending no done", int'(tc_o), 0);
    load_pend(0);
    exp_q.push_back(-1);
    chunk_arrive_i = 1; tick(); chunk_arrive_i = 0;
    repeat (2) tick();
    chk("R8 release tc", int'(tc_o), 1);
    chk("R8 release code", int'(intr_code_o), 16);
    chk("R8 drained", exp_q.size(), 0);

    // R9 restart while pieces move
    load_pend(-200);
    cnt_lo_i = 100; cnt_mid_i = 0; cmd_phase_i = 0;
    start_i = 1; tick(); start_i = 0;
    @(negedge clk);
    exp_q.push_back(10); exp_q.push_back(10); exp_q.push_back(10);
    avail_i = 10;
    repeat (3) @(posedge clk);
    #1 start_i = 1; cnt_lo_i = 7;
    tick(); start_i = 0;
    exp_q.push_back(7); exp_q.push_back(-1);
    @(negedge clk);
    chk("R9 no piece on restart", int'(piece_valid_o), 0);
    chk("R9 new chunk", int'(chunk_len_o), 7);
    chk("R9 remain reloaded", int'(remain_o), 7);
    repeat (3) tick();
    avail_i = 0;
    @(negedge clk);
    chk("R9 pending", int'(pending_o), -163);
    chk("R9 drained", exp_q.size(), 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule